// File: doc/BRIEF.md
# Granule Memory Tag Checker

This block guards memory accesses with small lock tags kept per memory granule. Every 16-byte granule owns a 4-bit tag in a side store. A 64-bit pointer carries its own 4-bit key in bits [59:56]. An access passes when that key matches the stored tag of the granule the pointer addresses, and faults when it does not.

An allocator uses three requests. Generate-tag returns a random nonzero tag and the caller's pointer rewritten to carry it. Set-tag paints a run of granules with one tag, for a new allocation or to retag freed memory so that stale pointers fault. Access performs the check. A check-enable input can turn checking off. Pointers whose key is all ones count as untagged. A sandbox mode splits the tag into a sandbox bit (pointer bit 56) and a 3-bit user tag (bits [59:57]).

Top module: `granule_tag_checker`

## Requirements
- R1: After reset `busy` and `rspValid` are 0 and every stored tag is 0, so an access with key 0 passes at any granule.
- R2: An accepted access (`reqOp`=2) gives `rspValid`=1 in the next cycle. `rspPtr` equals the request pointer and `rspTag` is the stored tag. The granule index is pointer bits [4+IDX_W-1:4], and no other pointer bit selects the granule.
- R3: With checking enabled and sandbox mode off, an access faults exactly when the key in bits [59:56] differs from the stored tag, unless the key is 4'hF.
- R4: An accepted generate (`reqOp`=0) answers in the next cycle with `rspFault`=0. `rspTag` is never 0, and `rspPtr` equals the request pointer with bits [59:56] replaced by `rspTag`.
- R5: In a generate, bit k of `excludeMask` forbids tag value k. If the mask forbids every otherwise legal value, the mask is ignored.
- R6: An accepted set (`reqOp`=1) with `reqCount`=N writes `reqTag` to N granules starting at the pointer's index, one per cycle, wrapping modulo the store depth. `busy` is high for exactly N cycles after acceptance, and N=0 changes nothing.
- R7: Requests presented while `busy` is high are not accepted and produce no response.
- R8: When `checkEn` is 0, no access faults.
- R9: In sandbox mode an access faults when bit 56 differs from the stored bit 0, or when bits [59:57] differ from stored bits [3:1]. A user field of 3'b111 skips only the user comparison. A generate in this mode keeps request bit 56 as tag bit 0 and returns a nonzero user field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| checkEn | input | 1 | 1 enables tag comparison |
| sandboxMode | input | 1 | 1 splits the tag into a sandbox bit and user bits |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | 0 generate, 1 set, 2 access, 3 none |
| reqPtr | input | 64 | Request pointer (key in [59:56], granule index in [4+IDX_W-1:4]) |
| reqCount | input | CNT_W | Granule count for set |
| reqTag | input | 4 | Tag written by set |
| excludeMask | input | 16 | Tags forbidden for generate |
| busy | output | 1 | Range write in progress; requests are not accepted |
| rspValid | output | 1 | Response for a generate or access |
| rspFault | output | 1 | Access tag mismatch |
| rspTag | output | 4 | Generated tag, or the stored tag on access |
| rspPtr | output | 64 | Tagged pointer, or the access pointer unchanged |

## Verification
The bench targets range writes that wrap past the last granule. A design that did not wrap would leave the low granules untouched, and later accesses with the new key would fault there. It checks that a zero-length set does not hang `busy`, and that an access issued during the last write cycle is dropped rather than answered with a stale tag. Generate is driven with masks that leave a single legal value, which a picker without a full search would miss. Masks that forbid every value must still yield a nonzero tag. Sandbox cases pair an untagged user field with a wrong sandbox bit, which a design that treats all-ones as a full bypass would pass.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  localparam int TAG_W    = 4;
  localparam int TAG_LO   = 56;
  localparam int GRAN_LSB = 4;

  typedef enum logic [1:0] {
    OP_GEN = 2'd0,
    OP_SET = 2'd1,
    OP_ACC = 2'd2,
    OP_NOP = 2'd3
  } op_e;

  typedef struct packed {
    logic genStb;
    logic accStb;
    logic wrEn;
  } strobe_t;
endpackage

// File: rtl/gtc_ctrl.sv
module gtc_ctrl
  import gtc_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  op_e              reqOp,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [TAG_W-1:0] reqTag,
  output logic             busy,
  output strobe_t          strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [TAG_W-1:0] wrTag
);
  logic [CNT_W-1:0] remain;
  logic             accept;

  assign accept = reqValid && !busy;

  always_comb begin
    strb.wrEn   = busy;
    strb.genStb = accept && (reqOp == OP_GEN);
    strb.accStb = accept && (reqOp == OP_ACC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
      wrIdx  <= '0;
      wrTag  <= '0;
    end else if (busy) begin
      wrIdx  <= wrIdx + 1'b1;
      remain <= remain - 1'b1;
      if (remain == 1) busy <= 1'b0;
    end else if (accept && reqOp == OP_SET && reqCount != 0) begin
      busy   <= 1'b1;
      wrIdx  <= reqIdx;
      remain <= reqCount;
      wrTag  <= reqTag;
    end
  end

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.genStb || strb.accStb));
  assert_count_live_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> remain != 0);
  assert_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> wrIdx == $past(wrIdx) + 1'b1);
endmodule

// File: rtl/gtc_datapath.sv
module gtc_datapath
  import gtc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [TAG_W-1:0] wrTag,
  input  logic             checkEn,
  input  logic             sandboxMode,
  input  logic [63:0]      reqPtr,
  input  logic [15:0]      excludeMask,
  output logic             rspValid,
  output logic             rspFault,
  output logic [TAG_W-1:0] rspTag,
  output logic [63:0]      rspPtr
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int NTAGS  = 1 << TAG_W;

  logic [TAG_W-1:0] tagStore [DEPTH];
  logic [15:0]      lfsr;
  logic [IDX_W-1:0] rdIdx;
  logic [TAG_W-1:0] storedTag, ptrTag, pickTag;
  logic             mismatch, wasGen;
  logic [15:0]      maskQ;
  logic             anyLegalQ;

  assign rdIdx     = reqPtr[GRAN_LSB +: IDX_W];
  assign storedTag = tagStore[rdIdx];
  assign ptrTag    = reqPtr[TAG_LO +: TAG_W];

  function automatic logic legal(input logic [TAG_W-1:0] v, input logic sbx, input logic sb);
    if (v == 0) return 1'b0;
    if (sbx) return (v[0] == sb) && (v[TAG_W-1:1] != 0);
    return 1'b1;
  endfunction

  logic anyLegal;
  always_comb begin
    logic found;
    logic [TAG_W-1:0] c;
    anyLegal = 1'b0;
    for (int v = 0; v < NTAGS; v++)
      if (legal(TAG_W'(v), sandboxMode, reqPtr[TAG_LO]) && !excludeMask[v]) anyLegal = 1'b1;
    found   = 1'b0;
    pickTag = '0;
    for (int k = 0; k < NTAGS; k++) begin
      c = lfsr[TAG_W-1:0] + TAG_W'(k);
      if (!found && legal(c, sandboxMode, reqPtr[TAG_LO]) && (!anyLegal || !excludeMask[c])) begin
        found   = 1'b1;
        pickTag = c;
      end
    end
  end

  always_comb begin
    logic userUntagged;
    userUntagged = ptrTag[TAG_W-1:1] == '1;
    if (!checkEn)
      mismatch = 1'b0;
    else if (sandboxMode)
      mismatch = (ptrTag[0] != storedTag[0]) ||
                 (!userUntagged && ptrTag[TAG_W-1:1] != storedTag[TAG_W-1:1]);
    else
      mismatch = (ptrTag != '1) && (ptrTag != storedTag);
  end

  always_ff @(posedge clk) begin
    if (!rstN) lfsr <= 16'hACE1;
    else       lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) tagStore[i] <= '0;
    end else if (strb.wrEn) begin
      tagStore[wrIdx] <= wrTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspFault  <= 1'b0;
      rspTag    <= '0;
      rspPtr    <= '0;
      wasGen    <= 1'b0;
      maskQ     <= '0;
      anyLegalQ <= 1'b0;
    end else begin
      rspValid  <= strb.genStb || strb.accStb;
      wasGen    <= strb.genStb;
      maskQ     <= excludeMask;
      anyLegalQ <= anyLegal;
      if (strb.genStb) begin
        rspFault <= 1'b0;
        rspTag   <= pickTag;
        rspPtr   <= {reqPtr[63:TAG_LO+TAG_W], pickTag, reqPtr[TAG_LO-1:0]};
      end else if (strb.accStb) begin
        rspFault <= mismatch;
        rspTag   <= storedTag;
        rspPtr   <= reqPtr;
      end
    end
  end

  assert_lfsr_live_R4: assert property (@(posedge clk) disable iff (!rstN) lfsr != 0);
  assert_gen_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && wasGen) |-> (rspTag != 0 && !rspFault));
  assert_gen_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && wasGen && anyLegalQ) |-> !maskQ[rspTag]);
  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.accStb && !checkEn) |-> (rspValid && !rspFault));
  assert_ptr_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.accStb) |-> rspPtr == $past(reqPtr));
endmodule

// File: rtl/granule_tag_checker.sv
module granule_tag_checker
  import gtc_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             checkEn,
  input  logic             sandboxMode,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [63:0]      reqPtr,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [3:0]       reqTag,
  input  logic [15:0]      excludeMask,
  output logic             busy,
  output logic             rspValid,
  output logic             rspFault,
  output logic [3:0]       rspTag,
  output logic [63:0]      rspPtr
);
  strobe_t          strb;
  logic [IDX_W-1:0] wrIdx;
  logic [TAG_W-1:0] wrTag;

  gtc_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(op_e'(reqOp)),
    .reqIdx(reqPtr[GRAN_LSB +: IDX_W]), .reqCount(reqCount), .reqTag(reqTag),
    .busy(busy), .strb(strb), .wrIdx(wrIdx), .wrTag(wrTag)
  );

  gtc_datapath #(.IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .wrTag(wrTag),
    .checkEn(checkEn), .sandboxMode(sandboxMode), .reqPtr(reqPtr),
    .excludeMask(excludeMask), .rspValid(rspValid), .rspFault(rspFault),
    .rspTag(rspTag), .rspPtr(rspPtr)
  );
endmodule

// File: tb/tb_granule_tag_checker.sv
`timescale 1ns/1ps
module tb_granule_tag_checker;
  localparam int IDX_W = 6;
  localparam int CNT_W = 7;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 0, rstN = 0, checkEn = 1, sandboxMode = 0, reqValid = 0;
  logic [1:0] reqOp = 2'd3;
  logic [63:0] reqPtr = '0;
  logic [CNT_W-1:0] reqCount = '0;
  logic [3:0] reqTag = '0;
  logic [15:0] excludeMask = '0;
  logic busy, rspValid, rspFault;
  logic [3:0] rspTag;
  logic [63:0] rspPtr;

  int compared = 0, mismatched = 0;
  logic [3:0] model [DEPTH];

  always #4 clk = ~clk;

  granule_tag_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkPtr(input int idx, input logic [3:0] key);
    logic [63:0] p;
    p = {$urandom, $urandom};
    p[59:56] = key;
    p[4 +: IDX_W] = IDX_W'(idx);
    return p;
  endfunction

  function automatic bit expFault(input logic [63:0] p, input bit sbx, input bit en);
    logic [3:0] k, s;
    k = p[59:56];
    s = model[p[4 +: IDX_W]];
    if (!en) return 0;
    if (sbx) return (k[0] != s[0]) || (k[3:1] != 3'b111 && k[3:1] != s[3:1]);
    return (k != 4'hF) && (k != s);
  endfunction

  task automatic doAccess(input logic [63:0] p, input string req);
    bit ef;
    @(negedge clk);
    reqValid = 1; reqOp = 2'd2; reqPtr = p;
    ef = expFault(p, sandboxMode, checkEn);
    @(negedge clk);
    reqValid = 0;
    check(rspValid === 1'b1, req, rspValid, 1);
    check(rspFault === ef, req, rspFault, ef);
    check(rspPtr === p, req, rspPtr, p);
    check(rspTag === model[p[4 +: IDX_W]], req, rspTag, model[p[4 +: IDX_W]]);
  endtask

  task automatic doGen(input logic [63:0] p, input logic [15:0] m, input string req);
    logic [63:0] ep;
    bit any, legalT;
    @(negedge clk);
    reqValid = 1; reqOp = 2'd0; reqPtr = p; excludeMask = m;
    @(negedge clk);
    reqValid = 0;
    any = 0;
    for (int v = 1; v < 16; v++)
      if (!m[v] && (!sandboxMode || (v[0] == p[56] && v[3:1] != 0))) any = 1;
    legalT = rspTag != 0 && (!sandboxMode || (rspTag[0] == p[56] && rspTag[3:1] != 0));
    ep = p; ep[59:56] = rspTag;
    check(rspValid === 1'b1 && rspFault === 1'b0, req, {rspValid, rspFault}, 2'b10);
    check(legalT, req, rspTag, 0);
    check(!any || !m[rspTag], req, rspTag, m);
    check(rspPtr === ep, req, rspPtr, ep);
  endtask

  task automatic doSet(input int idx, input int cnt, input logic [3:0] t, input bit probe, input string req);
    int n;
    @(negedge clk);
    reqValid = 1; reqOp = 2'd1; reqPtr = mkPtr(idx, 4'h0); reqCount = CNT_W'(cnt); reqTag = t;
    @(negedge clk);
    reqValid = 0;
    n = 0;
    while (busy === 1'b1 && n < 200) begin
      if (probe && n == 0) begin reqValid = 1; reqOp = 2'd2; reqPtr = mkPtr(idx, t); end
      n++;
      @(negedge clk);
      if (probe && n == 1) begin
        reqValid = 0;
        check(rspValid === 1'b0, "R7 request during busy ignored", rspValid, 0);
      end
    end
    check(n == cnt, req, n, cnt);
    for (int k = 0; k < cnt; k++) model[(idx + k) % DEPTH] = t;
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < DEPTH; i++) model[i] = 4'h0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(busy === 1'b0 && rspValid === 1'b0, "R1 reset outputs", {busy, rspValid}, 0);
    doAccess(mkPtr(17, 4'h0), "R1 reset tag zero passes");
    doAccess(mkPtr(40, 4'h3), "R3 mismatch faults");
    doSet(62, 4, 4'h5, 0, "R6 wrap set busy length");
    doAccess(mkPtr(1, 4'h5), "R6 wrapped granule written");
    doAccess(mkPtr(2, 4'h0), "R6 granule past range untouched");
    doSet(10, 0, 4'h9, 0, "R6 zero count no busy");
    doAccess(mkPtr(10, 4'h0), "R6 zero count no write");
    doSet(20, 1, 4'hA, 1, "R7 single set with probe");
    doAccess(mkPtr(20, 4'hA), "R2 access after set");
    doAccess(mkPtr(20, 4'hF), "R3 untagged key passes");
    checkEn = 0;
    doAccess(mkPtr(20, 4'h2), "R8 check disabled");
    checkEn = 1;
    doGen(mkPtr(5, 4'h0), 16'hFDFF, "R5 single legal value");
    check(rspTag === 4'h9, "R5 only tag 9 allowed", rspTag, 9);
    doGen(mkPtr(5, 4'h0), 16'hFFFF, "R5 all excluded falls back");
    sandboxMode = 1;
    doSet(30, 2, 4'h5, 0, "R6 set for sandbox");
    doAccess(mkPtr(30, 4'h7), "R9 user bits differ");
    doAccess(mkPtr(30, 4'hE), "R9 untagged user wrong sandbox bit");
    doAccess(mkPtr(31, 4'hF), "R9 untagged user right sandbox bit");
    doAccess(mkPtr(31, 4'h4), "R9 sandbox bit differs");
    doGen(mkPtr(3, 4'h1), 16'h0000, "R9 sandbox gen keeps bit");
    doGen(mkPtr(3, 4'h0), 16'hFFEF, "R9 sandbox gen with mask");
    check(rspTag === 4'h4, "R9 only tag 4 allowed", rspTag, 4);
    sandboxMode = 0;
    for (int it = 0; it < 400; it++) begin
      int r, idx;
      r = $urandom % 10;
      idx = $urandom % DEPTH;
      sandboxMode = ($urandom % 4) == 0;
      checkEn = ($urandom % 8) != 0;
      if (r < 2) doSet(idx, $urandom % 9, 4'($urandom), 0, "R6 random set");
      else if (r < 4) doGen(mkPtr(idx, 4'($urandom)), 16'($urandom), "R4 random gen");
      else if (r < 8) doAccess(mkPtr(idx, model[idx]), "R2 random matching access");
      else doAccess(mkPtr(idx, 4'($urandom)), "R3 random access");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule